// File: doc/BRIEF.md
# Addressable LED stream encoder

This block turns a stream of pixel colour words into the pulse-width-coded waveform that a chain of addressable LEDs reads from one data wire. A pixel is offered through a valid/ready handshake as separate 8-bit red, green, blue and white values, together with a flag that marks the last pixel of a frame. The block rearranges the components into the order the LEDs expect, then sends every bit as a fixed-length slot. The line is high at the start of each slot and low at the end, and the length of the high part carries the bit value.

Each slot is four equal time quanta. The number of clock cycles in one quantum comes from a clock-frequency parameter and a quantum-length parameter. A zero is sent as one high quantum, and a one as two or three high quanta, set by a parameter. The pixels of a frame follow each other with no gap. When a frame ends, or when no new pixel is ready at the end of a pixel, the line is held low for a reset interval whose length in microseconds is also a parameter. Only after that interval does the block take a new frame.

Top module: `led_stream_enc`

## Requirements
- R1: After reset, and whenever `busy` is low, `led_dout` is low and `px_ready` is high.
- R2: A pixel is sent as 24 bits when `WHITE_EN` is 0, or as 32 bits when it is 1. Each component is sent most significant bit first.
- R3: Wire slot k (k = 0 is sent first) carries the component selected by `WIRE_ORDER[2k+1:2k]`, with the code 0 for red, 1 for green, 2 for blue and 3 for white. The default value 8'hE1 gives green, then red, then blue.
- R4: Each bit slot lasts exactly 4 quanta of Q cycles, where Q = CLK_HZ x QUANT_NS / 10^9 and is at least 1. The line is high from the start of the slot and low for the rest of it. A zero is high for exactly 1 quantum.
- R5: A one is high for exactly `ONE_QUANTA` quanta, where `ONE_QUANTA` is 2 or 3.
- R6: A pixel accepted while the block is idle puts the line high on the first cycle after the acceptance edge.
- R7: `px_ready` is high while the block is busy only on the final cycle of the last slot of a pixel that did not carry the frame-end flag. A pixel accepted on that cycle starts on the next cycle, with no gap.
- R8: After a pixel with the frame-end flag, or at the end of a pixel when no new pixel is offered, the line is held low for exactly CLK_HZ/10^6 x RESET_US cycles. `px_ready` stays low during this time, and the block is idle on the next cycle.
- R9: `busy` is high from the first cycle of the first bit until the last cycle of the reset interval, and low otherwise.
- R10: A pixel held on the inputs while `px_ready` is low is not consumed. It is sent exactly once, after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| px_valid | input | 1 | Pixel on the inputs is valid |
| px_ready | output | 1 | Encoder accepts the pixel on this cycle |
| px_r | input | 8 | Red component |
| px_g | input | 8 | Green component |
| px_b | input | 8 | Blue component |
| px_w | input | 8 | White component (used only when WHITE_EN is 1) |
| px_last | input | 1 | Pixel is the last of its frame |
| led_dout | output | 1 | Serial LED data line |
| busy | output | 1 | Bits or the reset interval are in progress |

## Verification
The bench attacks the hand-off between pixels. A design whose ready window is off by one cycle would either stretch the final low quantum or cut it short. Such a design would also accept a new pixel after a frame-end pixel, without first holding the reset interval. Frames that end by starvation rather than by the flag check that an underrun still produces a full-length reset. A four-component instance with a scrambled wire order and three-quanta ones catches components placed in the wrong slot, bits sent least significant first, and high widths wrong by a whole quantum. Pixels held on the inputs for thousands of cycles while the block is busy would show up twice in the decoded stream if the block consumed them early.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

   typedef enum logic [1:0] {
      ENC_IDLE = 2'd0,
      ENC_BITS = 2'd1,
      ENC_RST  = 2'd2
   } enc_state_e;

   localparam int QUANTA_PER_SLOT = 4;

   // Clock cycles per quantum, never below one.
   function automatic int quantum_cycles(input longint clk_hz, input longint q_ns);
      longint c;
      c = (clk_hz * q_ns) / 64'd1_000_000_000;
      if (c < 1) c = 1;
      return int'(c);
   endfunction

   // Clock cycles in the closing low interval, never below one.
   function automatic int reset_cycles(input longint clk_hz, input longint r_us);
      longint c;
      c = (clk_hz / 64'd1_000_000) * r_us;
      if (c < 1) c = 1;
      return int'(c);
   endfunction

   // Each used slot selects a legal component, and no component is used twice.
   function automatic bit order_ok(input logic [7:0] ord, input int ncomp);
      bit [3:0] seen;
      seen = '0;
      for (int k = 0; k < ncomp; k++) begin
         if (int'(ord[2*k +: 2]) >= ncomp) return 1'b0;
         if (seen[ord[2*k +: 2]]) return 1'b0;
         seen[ord[2*k +: 2]] = 1'b1;
      end
      return 1'b1;
   endfunction

endpackage

// File: rtl/led_quantum_timer.sv
module led_quantum_timer #(
   parameter int QCYC = 30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       run,
   output logic [1:0] q_idx,
   output logic       slot_last
);
   logic       q_end;
   logic [1:0] q_idx_q;

   generate
      if (QCYC > 1) begin : g_div
         localparam int QW = $clog2(QCYC);
         logic [QW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
               cnt_q <= '0;
            end else if (run) begin
               cnt_q <= q_end ? '0 : cnt_q + 1'b1;
            end
         end
         assign q_end = (cnt_q == QW'(QCYC - 1));
      end else begin : g_nodiv
         assign q_end = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         q_idx_q <= 2'd0;
      end else if (run && q_end) begin
         q_idx_q <= q_idx_q + 2'd1;
      end
   end

   assign q_idx     = q_idx_q;
   assign slot_last = q_end && (q_idx_q == 2'd3);
endmodule

// File: rtl/led_pixel_packer.sv
module led_pixel_packer #(
   parameter int         NCOMP      = 3,
   parameter logic [7:0] WIRE_ORDER = 8'hE1,
   localparam int        NBITS      = NCOMP * 8
) (
   input  logic [7:0]       pix_r,
   input  logic [7:0]       pix_g,
   input  logic [7:0]       pix_b,
   input  logic [7:0]       pix_w,
   output logic [NBITS-1:0] word
);
   logic [7:0] comp_set [4];

   assign comp_set[0] = pix_r;
   assign comp_set[1] = pix_g;
   assign comp_set[2] = pix_b;
   assign comp_set[3] = pix_w;

   // Slot 0 lands in the top byte so it leaves the shifter first.
   generate
      for (genvar k = 0; k < NCOMP; k++) begin : g_slot
         localparam logic [1:0] SEL = WIRE_ORDER[2*k +: 2];
         assign word[NBITS-1-8*k -: 8] = comp_set[SEL];
      end
   endgenerate
endmodule

// File: rtl/led_bit_shifter.sv
module led_bit_shifter #(
   parameter int NBITS = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             advance,
   input  logic [NBITS-1:0] word_in,
   output logic             cur_bit,
   output logic             on_last
);
   localparam int BW = $clog2(NBITS);

   logic [NBITS-1:0] sh_q;
   logic [BW-1:0]    bidx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         bidx_q <= '0;
      end else if (load) begin
         sh_q   <= word_in;
         bidx_q <= '0;
      end else if (advance) begin
         sh_q   <= {sh_q[NBITS-2:0], 1'b0};
         bidx_q <= bidx_q + 1'b1;
      end
   end

   assign cur_bit = sh_q[NBITS-1];
   assign on_last = (bidx_q == BW'(NBITS - 1));
endmodule

// File: rtl/led_stream_enc.sv
module led_stream_enc
   import led_enc_pkg::*;
#(
   parameter int         CLK_HZ     = 100_000_000,
   parameter int         QUANT_NS   = 300,
   parameter int         ONE_QUANTA = 2,
   parameter int         WHITE_EN   = 0,
   parameter int         RESET_US   = 50,
   parameter logic [7:0] WIRE_ORDER = 8'hE1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       px_valid,
   output logic       px_ready,
   input  logic [7:0] px_r,
   input  logic [7:0] px_g,
   input  logic [7:0] px_b,
   input  logic [7:0] px_w,
   input  logic       px_last,
   output logic       led_dout,
   output logic       busy
);
   localparam int NCOMP = (WHITE_EN != 0) ? 4 : 3;
   localparam int NBITS = NCOMP * 8;
   localparam int QCYC  = quantum_cycles(CLK_HZ, QUANT_NS);
   localparam int RCYC  = reset_cycles(CLK_HZ, RESET_US);
   localparam int RW    = $clog2(RCYC + 1);

   initial begin
      assert (ONE_QUANTA == 2 || ONE_QUANTA == 3)
         else $error("ONE_QUANTA must be 2 or 3");
      assert (ONE_QUANTA < QUANTA_PER_SLOT)
         else $error("a one must end low");
      assert (order_ok(WIRE_ORDER, NCOMP))
         else $error("WIRE_ORDER repeats or exceeds the component set");
      assert (CLK_HZ >= 1_000_000)
         else $error("CLK_HZ must be at least 1 MHz");
   end

   enc_state_e        state_q;
   logic [RW-1:0]     rcnt_q;
   logic              last_q;
   logic [1:0]        q_idx;
   logic              slot_last;
   logic              cur_bit;
   logic              bit_last;
   logic [NBITS-1:0]  packed_word;
   logic              pix_end;
   logic              take;
   logic              advance;
   logic [2:0]        hi_quanta;

   led_pixel_packer #(
      .NCOMP      (NCOMP),
      .WIRE_ORDER (WIRE_ORDER)
   ) u_pack (
      .pix_r (px_r),
      .pix_g (px_g),
      .pix_b (px_b),
      .pix_w (px_w),
      .word  (packed_word)
   );

   led_quantum_timer #(
      .QCYC (QCYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (take),
      .run       (state_q == ENC_BITS),
      .q_idx     (q_idx),
      .slot_last (slot_last)
   );

   led_bit_shifter #(
      .NBITS (NBITS)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (take),
      .advance (advance),
      .word_in (packed_word),
      .cur_bit (cur_bit),
      .on_last (bit_last)
   );

   assign pix_end  = (state_q == ENC_BITS) && slot_last && bit_last;
   assign px_ready = (state_q == ENC_IDLE) || (pix_end && !last_q);
   assign take     = px_valid && px_ready;
   assign advance  = (state_q == ENC_BITS) && slot_last && !bit_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENC_IDLE;
         rcnt_q  <= '0;
         last_q  <= 1'b0;
      end else begin
         if (take) last_q <= px_last;
         unique case (state_q)
            ENC_IDLE: begin
               if (take) state_q <= ENC_BITS;
            end
            ENC_BITS: begin
               if (pix_end && !take) begin
                  state_q <= ENC_RST;
                  rcnt_q  <= '0;
               end
            end
            ENC_RST: begin
               if (rcnt_q == RW'(RCYC - 1)) begin
                  state_q <= ENC_IDLE;
                  rcnt_q  <= '0;
               end else begin
                  rcnt_q <= rcnt_q + 1'b1;
               end
            end
            default: state_q <= ENC_IDLE;
         endcase
      end
   end

   assign hi_quanta = cur_bit ? 3'(ONE_QUANTA) : 3'd1;
   assign led_dout  = (state_q == ENC_BITS) && ({1'b0, q_idx} < hi_quanta);
   assign busy      = (state_q != ENC_IDLE);
endmodule

// File: rtl/led_stream_enc_chk.sv
module led_stream_enc_chk
   import led_enc_pkg::*;
#(
   parameter int CLK_HZ     = 100_000_000,
   parameter int QUANT_NS   = 300,
   parameter int ONE_QUANTA = 2
) (
   input logic clk,
   input logic rst_n,
   input logic px_valid,
   input logic px_ready,
   input logic led_dout,
   input logic busy
);
   localparam int QCYC     = quantum_cycles(CLK_HZ, QUANT_NS);
   localparam int HIGH_MAX = ONE_QUANTA * QCYC;

   int hi_run;

   always_ff @(posedge clk) begin
      if (!rst_n)        hi_run <= 0;
      else if (led_dout) hi_run <= hi_run + 1;
      else               hi_run <= 0;
   end

   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !led_dout);

   assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> px_ready);

   assert_start_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && px_ready && !busy) |=> led_dout);

   assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && px_ready) |=> busy);

   assert_join_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && px_ready) |-> !led_dout);

   assert_tail_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !$past(led_dout));

   assert_high_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      led_dout |-> (hi_run < HIGH_MAX));

   assert_high_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(led_dout) |-> (hi_run >= QCYC));
endmodule

bind led_stream_enc led_stream_enc_chk #(
   .CLK_HZ     (CLK_HZ),
   .QUANT_NS   (QUANT_NS),
   .ONE_QUANTA (ONE_QUANTA)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .px_valid (px_valid),
   .px_ready (px_ready),
   .led_dout (led_dout),
   .busy     (busy)
);

// File: tb/led_stream_enc_tb.sv
package led_tb_pkg;
   // Expected wire word, slot 0 in the most significant used byte.
   function automatic logic [31:0] wire_word(input int white, input logic [7:0] ord,
                                             input logic [7:0] r, input logic [7:0] g,
                                             input logic [7:0] b, input logic [7:0] w);
      logic [31:0] acc;
      logic [7:0]  c;
      int          n;
      acc = '0;
      n = (white != 0) ? 4 : 3;
      for (int k = 0; k < n; k++) begin
         case (ord[2*k +: 2])
            2'd0: c = r;
            2'd1: c = g;
            2'd2: c = b;
            default: c = w;
         endcase
         acc = (acc << 8) | {24'd0, c};
      end
      return acc;
   endfunction
endpackage

module led_ref_model
   import led_tb_pkg::*;
#(
   parameter int         WHITE = 0,
   parameter logic [7:0] ORDER = 8'hE1,
   parameter int         QC    = 30,
   parameter int         ONEQ  = 2,
   parameter int         RSTC  = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       valid,
   input  logic [7:0] r,
   input  logic [7:0] g,
   input  logic [7:0] b,
   input  logic [7:0] w,
   input  logic       last,
   output logic       e_dout,
   output logic       e_ready,
   output logic       e_busy
);
   bit          lvl_q[$];
   int          rst_left = 0;
   bit          cur_last = 0;
   logic        m_dout = 1'b0;
   logic        m_ready = 1'b1;
   logic        m_busy = 1'b0;

   assign e_dout  = m_dout;
   assign e_ready = m_ready;
   assign e_busy  = m_busy;

   always @(posedge clk) begin
      if (!rst_n) begin
         lvl_q.delete();
         rst_left = 0;
         cur_last = 0;
      end else begin
         bit          acc;
         logic [31:0] wd;
         int          nb;
         acc = valid && m_ready;
         if (rst_left > 0) begin
            rst_left--;
         end else if (lvl_q.size() > 0) begin
            void'(lvl_q.pop_front());
            if (lvl_q.size() == 0 && !acc) rst_left = RSTC;
         end
         if (acc) begin
            cur_last = last;
            nb = (WHITE != 0) ? 32 : 24;
            wd = wire_word(WHITE, ORDER, r, g, b, w);
            for (int i = nb - 1; i >= 0; i--) begin
               int hq;
               hq = wd[i] ? ONEQ : 1;
               for (int qq = 0; qq < 4; qq++)
                  for (int c = 0; c < QC; c++)
                     lvl_q.push_back(qq < hq);
            end
         end
      end
      m_dout  = (lvl_q.size() > 0) ? lvl_q[0] : 1'b0;
      m_busy  = (lvl_q.size() > 0) || (rst_left > 0);
      m_ready = (lvl_q.size() == 0 && rst_left == 0) || (lvl_q.size() == 1 && !cur_last);
   end
endmodule

module led_stream_enc_tb;
   import led_tb_pkg::*;

   localparam logic [7:0] ORD_A = 8'hE1;
   localparam logic [7:0] ORD_B = 8'h4B;
   localparam int QC_A = 30, QC_B = 10;
   localparam int ONE_A = 2, ONE_B = 3;
   localparam int NB_A = 24, NB_B = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_b = 1'b0;
   logic in_valid = 1'b0;
   logic [7:0] in_r = '0, in_g = '0, in_b = '0, in_w = '0;
   logic in_last = 1'b0;

   logic va, vb;
   logic ready_a, dout_a, busy_a, ready_b, dout_b, busy_b;
   logic er_a, ed_a, eb_a, er_b, ed_b, eb_b;

   int n_checks = 0;
   int n_err = 0;
   bit finished = 0;

   logic [31:0] exp_a[$];
   logic [31:0] exp_b[$];
   int          hi_run[2];
   logic [31:0] dec_w[2];
   int          dec_n[2];

   always #5 clk = ~clk;

   assign va = in_valid && !sel_b;
   assign vb = in_valid && sel_b;

   led_stream_enc u_dut (
      .clk (clk), .rst_n (rst_n), .px_valid (va), .px_ready (ready_a),
      .px_r (in_r), .px_g (in_g), .px_b (in_b), .px_w (in_w), .px_last (in_last),
      .led_dout (dout_a), .busy (busy_a)
   );

   led_stream_enc #(
      .CLK_HZ (100_000_000), .QUANT_NS (100), .ONE_QUANTA (ONE_B),
      .WHITE_EN (1), .RESET_US (80), .WIRE_ORDER (ORD_B)
   ) u_dut_w (
      .clk (clk), .rst_n (rst_n), .px_valid (vb), .px_ready (ready_b),
      .px_r (in_r), .px_g (in_g), .px_b (in_b), .px_w (in_w), .px_last (in_last),
      .led_dout (dout_b), .busy (busy_b)
   );

   led_ref_model #(.WHITE(0), .ORDER(ORD_A), .QC(QC_A), .ONEQ(ONE_A), .RSTC(5000)) u_ref_a (
      .clk (clk), .rst_n (rst_n), .valid (va), .r (in_r), .g (in_g), .b (in_b), .w (in_w),
      .last (in_last), .e_dout (ed_a), .e_ready (er_a), .e_busy (eb_a)
   );

   led_ref_model #(.WHITE(1), .ORDER(ORD_B), .QC(QC_B), .ONEQ(ONE_B), .RSTC(8000)) u_ref_b (
      .clk (clk), .rst_n (rst_n), .valid (vb), .r (in_r), .g (in_g), .b (in_b), .w (in_w),
      .last (in_last), .e_dout (ed_b), .e_ready (er_b), .e_busy (eb_b)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
      end
   endtask

   // Bit decoder on the line: classifies each high pulse and rebuilds words.
   task automatic observe(input int k, input logic d);
      int qc, oneq, nb;
      logic [31:0] ew;
      qc   = (k == 0) ? QC_A : QC_B;
      oneq = (k == 0) ? ONE_A : ONE_B;
      nb   = (k == 0) ? NB_A : NB_B;
      if (d) begin
         hi_run[k]++;
      end else if (hi_run[k] > 0) begin
         if (hi_run[k] == qc) begin
            check(1'b1, "R4", "zero width", hi_run[k], qc);
            dec_w[k] = {dec_w[k][30:0], 1'b0};
         end else begin
            check(hi_run[k] == oneq * qc, "R5", "one width", hi_run[k], oneq * qc);
            dec_w[k] = {dec_w[k][30:0], 1'b1};
         end
         dec_n[k]++;
         hi_run[k] = 0;
         if (dec_n[k] == nb) begin
            if (k == 0) begin
               ew = (exp_a.size() > 0) ? exp_a.pop_front() : 32'hDEAD_BEEF;
            end else begin
               ew = (exp_b.size() > 0) ? exp_b.pop_front() : 32'hDEAD_BEEF;
            end
            check(dec_w[k] == ew, "R2 R3 R10", "decoded pixel word", dec_w[k], ew);
            dec_n[k] = 0;
            dec_w[k] = '0;
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(dout_a === ed_a, "R4", "line level A", dout_a, ed_a);
         check(ready_a === er_a, "R7", "ready A", ready_a, er_a);
         check(busy_a === eb_a, "R9 R8", "busy A", busy_a, eb_a);
         check(dout_b === ed_b, "R4", "line level B", dout_b, ed_b);
         check(ready_b === er_b, "R7", "ready B", ready_b, er_b);
         check(busy_b === eb_b, "R9 R8", "busy B", busy_b, eb_b);
         observe(0, dout_a);
         observe(1, dout_b);
      end
   end

   // Offer a pixel; it is held on the inputs until the encoder takes it.
   task automatic send(input bit to_b, input logic [7:0] r, input logic [7:0] g,
                       input logic [7:0] b, input logic [7:0] w, input bit lst);
      bit was_idle;
      sel_b = to_b;
      in_r = r; in_g = g; in_b = b; in_w = w; in_last = lst;
      in_valid = 1'b1;
      while (!(to_b ? ready_b : ready_a)) @(negedge clk);
      was_idle = !(to_b ? busy_b : busy_a);
      @(negedge clk);
      if (to_b) exp_b.push_back(wire_word(1, ORD_B, r, g, b, w));
      else      exp_a.push_back(wire_word(0, ORD_A, r, g, b, w));
      if (was_idle) check((to_b ? dout_b : dout_a) == 1'b1, "R6", "line high after take",
                          to_b ? dout_b : dout_a, 1);
      in_valid = 1'b0;
   endtask

   task automatic wait_idle(input bit to_b);
      while (to_b ? busy_b : busy_a) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      hi_run = '{0, 0};
      dec_n  = '{0, 0};
      dec_w  = '{32'd0, 32'd0};
      repeat (4) @(negedge clk);
      // R1: reset state
      check(dout_a == 1'b0 && busy_a == 1'b0, "R1", "A idle in reset", {dout_a, busy_a}, 0);
      check(ready_a == 1'b1 && ready_b == 1'b1, "R1", "ready in reset", {ready_a, ready_b}, 3);
      rst_n = 1'b1;
      @(negedge clk);
      check(dout_b == 1'b0 && busy_b == 1'b0, "R1", "B idle after reset", {dout_b, busy_b}, 0);

      // Single-pixel frame, then back-to-back three-pixel frame (R7).
      send(0, 8'hA5, 8'h3C, 8'h0F, 8'h00, 1'b1);
      send(0, 8'h12, 8'h34, 8'h56, 8'h00, 1'b0);
      send(0, 8'hFF, 8'h00, 8'h81, 8'h00, 1'b0);
      send(0, 8'h00, 8'hFF, 8'h7E, 8'h00, 1'b1);
      // Underrun: no frame-end flag and no follow-up pixel (R8).
      send(0, 8'hC3, 8'h99, 8'h66, 8'h00, 1'b0);
      wait_idle(0);
      check(ready_a == 1'b1, "R8", "ready after reset interval", ready_a, 1);

      // Four-component wire order, three-quanta ones.
      send(1, 8'h11, 8'h22, 8'h44, 8'h88, 1'b0);
      send(1, 8'hF0, 8'h0F, 8'hAA, 8'h55, 1'b1);
      send(1, 8'h01, 8'h80, 8'hFE, 8'h7F, 1'b1);
      wait_idle(1);
      wait_idle(0);
      repeat (3) @(negedge clk);
      check(exp_a.size() == 0, "R2", "A pixels outstanding", exp_a.size(), 0);
      check(exp_b.size() == 0, "R2", "B pixels outstanding", exp_b.size(), 0);
      check(dout_a == 1'b0 && dout_b == 1'b0, "R1", "lines idle low", {dout_a, dout_b}, 0);
      finish_run();
   end
endmodule